// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a countdown timer with a small register interface, intended to sit beside a local interrupt controller. Software programs a control word (vector, mask and mode), a divide configuration, and an initial count. The counter then decrements once every divided clock period. When it reaches zero it either reloads and keeps going (periodic) or parks at zero (one-shot). If the mask bit is clear, it also emits a one-cycle interrupt request that carries the programmed vector toward the interrupt core.

Writes use a 2-bit register select, a write strobe and a 32-bit data word. Reads are combinational on a separate select. A software-enable input gates the mask. While it is low, the control word is held masked, and anything written to it is stored masked.

Top module: `lctmr_top`

## Requirements
- R1: The register select decodes as 0 = control word, 1 = initial count, 2 = current count, 3 = divide configuration. After reset the control word reads 0x0001_0000 and the other three read 0.
- R2: Only bits 3, 1 and 0 of a divide-configuration write are stored. The rest read back as zero, so a write of 0xFFFF_FFFF reads as 0xB.
- R3: The divide code is {bit3, bit1, bit0}. Code 7 divides by 1, and any other code n divides by 2<<n (2 to 128). After a nonzero initial count N is written, the count reaches zero N*factor clocks after the write edge.
- R4: A nonzero write to the initial count stops any running count, restarts the clock divider, loads the current count and starts counting.
- R5: A zero write to the initial count leaves the timer stopped, with the current count at 0.
- R6: In periodic mode (control bit 17 = 1), reaching zero reloads the current count from the initial count, and counting continues.
- R7: In one-shot mode (control bit 17 = 0), reaching zero leaves the current count at 0 and stops the timer.
- R8: Reaching zero raises `irq_valid` for one cycle, with `irq_vector` equal to control bits 7:0, but only if the mask (control bit 16) is clear. Reload and stop happen whether the mask is set or not.
- R9: Only bits 0x300FF of the control word are writable. While `sw_enable` is low, the mask is forced to 1 on the next clock, and any control write is stored with the mask set.
- R10: The current count is read-only; a write with select 2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Software enable; low forces the mask |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions check several properties on every cycle:
- The divider always wraps after a tick.
- A running count is never zero and never exceeds the initial count.
- A zero initial-count write stops the timer.
- Zero events reload the count in periodic mode and stop it in one-shot mode.
- Requests appear only after an unmasked zero event.
- A low software enable always leaves the mask set.

Only the bench scenarios can show the things that depend on timing and programming sequences:
- The exact period for each divide code, including the non-contiguous code for divide-by-128.
- A restart while the timer is running.
- The write masks on read-back.
- That a write to the current count is ignored.

// File: rtl/lctmr_pkg.sv
package lctmr_pkg;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam int CTL_W  = 18;
  localparam int DIV_W  = 4;
  localparam int PRE_W  = 8;

  localparam int CTL_MASK_BIT = 16;
  localparam int CTL_PER_BIT  = 17;
  localparam logic [CTL_W-1:0] CTL_WR_MASK  = 18'h300FF;
  localparam logic [CTL_W-1:0] CTL_RST_VAL  = 18'h10000;
  localparam logic [DIV_W-1:0] DIV_WR_MASK  = 4'hB;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_DIV  = 2'd3
  } reg_sel_e;

  function automatic logic [PRE_W-1:0] div_factor(input logic [2:0] code);
    logic [PRE_W-1:0] f;
    if (code == 3'd7) f = PRE_W'(1);
    else              f = PRE_W'(2) << code;
    return f;
  endfunction
endpackage

// File: rtl/lctmr_prescaler.sv
module lctmr_prescaler
  import lctmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [2:0]       code,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] factor;
  logic             cnt_en;

  assign factor = div_factor(code);
  assign tick   = run && !clr && (cnt_q >= factor - PRE_W'(1));
  assign cnt_en = clr || run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the divider wraps on every tick
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/lctmr_counter.sv
module lctmr_counter
  import lctmr_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic             active,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] init,
  output logic             zero_evt
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] init_q;
  logic             cur_en;

  assign zero_evt = act_q && tick && !load && (cur_q <= CNT_W'(1));
  assign cur_en   = load || (act_q && tick);

  always_comb begin
    act_d = act_q;
    cur_d = cur_q;
    if (load) begin
      act_d = (load_val != '0);
      cur_d = load_val;
    end else if (zero_evt) begin
      if (periodic) begin
        cur_d = init_q;
      end else begin
        cur_d = '0;
        act_d = 1'b0;
      end
    end else if (act_q && tick) begin
      cur_d = cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cur_q  <= '0;
      init_q <= '0;
    end else begin
      if (cur_en) begin
        act_q <= act_d;
        cur_q <= cur_d;
      end
      if (load) init_q <= load_val;
    end
  end

  assign active = act_q;
  assign cur    = cur_q;
  assign init   = init_q;

  // R4: a running count is nonzero and bounded by the initial count
  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cur_q != '0) && (cur_q <= init_q));
  // R5: a zero initial-count write stops the timer
  p_zero_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!act_q && cur_q == '0));
  // R6: periodic reload
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && periodic) |=> (act_q && cur_q == $past(init_q)));
  // R7: one-shot stop
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !periodic) |=> (!act_q && cur_q == '0));
endmodule

// File: rtl/lctmr_ctlreg.sv
module lctmr_ctlreg
  import lctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_enable,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              div_wr,
  input  logic [DATA_W-1:0] div_data,
  output logic [CTL_W-1:0]  ctl,
  output logic [DIV_W-1:0]  div_cfg,
  output logic [2:0]        div_code
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [DIV_W-1:0] div_q;
  logic             ctl_en;

  assign ctl_en = ctl_wr || !sw_enable;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_data[CTL_W-1:0] & CTL_WR_MASK;
    if (!sw_enable) ctl_d[CTL_MASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST_VAL;
      div_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (div_wr) div_q <= div_data[DIV_W-1:0] & DIV_WR_MASK;
    end
  end

  assign ctl      = ctl_q;
  assign div_cfg  = div_q;
  assign div_code = {div_q[3], div_q[1], div_q[0]};

  // R9: a low software enable leaves the mask set
  p_mask_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |=> ctl_q[CTL_MASK_BIT]);
  // R2: the unwritable divide bit stays clear
  p_div_bit2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q[2] == 1'b0);
endmodule

// File: rtl/lctmr_top.sv
module lctmr_top
  import lctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_enable,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic [CTL_W-1:0]  ctl;
  logic [DIV_W-1:0]  div_cfg;
  logic [2:0]        div_code;
  logic              tick, active, zero_evt, load;
  logic [DATA_W-1:0] cur, init;
  logic              irq_q, irq_d;
  logic [VEC_W-1:0]  vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign load = wr_en && (wr_sel == SEL_INIT);

  lctmr_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_s), .sw_enable(sw_enable),
    .ctl_wr(wr_en && wr_sel == SEL_CTL), .ctl_data(wr_data),
    .div_wr(wr_en && wr_sel == SEL_DIV), .div_data(wr_data),
    .ctl(ctl), .div_cfg(div_cfg), .div_code(div_code)
  );

  lctmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_s), .clr(load), .run(active),
    .code(div_code), .tick(tick)
  );

  lctmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .load(load), .load_val(wr_data),
    .tick(tick), .periodic(ctl[CTL_PER_BIT]), .active(active),
    .cur(cur), .init(init), .zero_evt(zero_evt)
  );

  assign irq_d = zero_evt && !ctl[CTL_MASK_BIT];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (irq_d) vec_q <= ctl[VEC_W-1:0];
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CTL:  rd_data = {{(DATA_W-CTL_W){1'b0}}, ctl};
      SEL_INIT: rd_data = init;
      SEL_CUR:  rd_data = cur;
      default:  rd_data = {{(DATA_W-DIV_W){1'b0}}, div_cfg};
    endcase
  end

  // R8: a request follows only an unmasked zero event
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_s)
    irq_q |-> ($past(zero_evt) && !$past(ctl[CTL_MASK_BIT])));
  // R10: a current-count write alone leaves the count unchanged when idle
  p_cur_ro_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && wr_sel == SEL_CUR && !active) |=> $stable(cur));
endmodule

// File: tb/lctmr_top_test.sv
module lctmr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_enable = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd2;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  longint m_cur, m_init, m_ctl, m_div, m_pre;
  bit     m_act, m_irq;
  longint m_vec;

  lctmr_top uut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_init = 0; m_ctl = 'h10000; m_div = 0; m_pre = 0;
      m_act = 0; m_irq = 0; m_vec = 0;
    end else begin
      longint code, factor;
      code   = ((m_div >> 1) & 4) | (m_div & 3);
      factor = (code == 7) ? 1 : (2 << code);
      m_irq  = 0;
      if (wr_en && wr_sel == 2'd1) begin
        m_init = wr_data; m_cur = wr_data; m_act = (wr_data != 0); m_pre = 0;
      end else if (m_act) begin
        if (m_pre >= factor - 1) begin
          m_pre = 0;
          if (m_cur == 1) begin
            if (!m_ctl[16]) begin m_irq = 1; m_vec = m_ctl & 'hFF; end
            if (m_ctl[17]) m_cur = m_init;
            else begin m_cur = 0; m_act = 0; end
          end else m_cur = m_cur - 1;
        end else m_pre = m_pre + 1;
      end else m_pre = 0;
      if (wr_en && wr_sel == 2'd0) m_ctl = wr_data & 'h300FF;
      if (!sw_enable) m_ctl = m_ctl | 'h10000;
      if (wr_en && wr_sel == 2'd3) m_div = wr_data & 'hB;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      check("R8 irq_valid", irq_valid, m_irq);
      if (m_irq) check("R8 irq_vector", irq_vector, m_vec);
      if (irq_valid) pulses++;
      if (rd_sel == 2'd2) check("R3 current count", rd_data, m_cur);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = rd_data;
    #1 rd_sel = 2'd2;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int p0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    rd(2'd0, v); check("R1 reset control", v, 'h10000);
    rd(2'd1, v); check("R1 reset init", v, 0);
    rd(2'd2, v); check("R1 reset current", v, 0);
    rd(2'd3, v); check("R1 reset divide", v, 0);

    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R2 divide mask", v, 'hB);

    // R7 one-shot, divide by 1
    wr(2'd0, 32'h0000_0040);
    p0 = pulses;
    wr(2'd1, 5);
    wait_cyc(10);
    check("R7 one-shot pulse count", pulses - p0, 1);
    rd(2'd2, v); check("R7 one-shot parked", v, 0);

    // R6 periodic, divide by 2
    wr(2'd3, 0);
    wr(2'd0, 32'h0002_0041);
    p0 = pulses;
    wr(2'd1, 3);
    wait_cyc(27);
    check("R6 periodic pulse count", pulses - p0, 4);

    // R5 zero write stops
    wr(2'd1, 0);
    p0 = pulses;
    wait_cyc(20);
    check("R5 stopped pulses", pulses - p0, 0);
    rd(2'd2, v); check("R5 stopped current", v, 0);

    // R8 masked periodic still reloads
    wr(2'd3, 'hB);
    wr(2'd0, 32'h0003_0042);
    p0 = pulses;
    wr(2'd1, 4);
    wait_cyc(20);
    check("R8 masked no pulse", pulses - p0, 0);
    rd(2'd2, v); check("R8 masked reload keeps running", v != 0, 1);
    wr(2'd1, 0);

    // R3 divide by 128 via non-contiguous code
    wr(2'd3, 'hA);
    wr(2'd0, 32'h0000_0043);
    p0 = pulses;
    wr(2'd1, 2);
    wait_cyc(250);
    check("R3 div128 early", pulses - p0, 0);
    wait_cyc(10);
    check("R3 div128 on time", pulses - p0, 1);

    // R4 restart while running
    wr(2'd3, 'hB);
    wr(2'd0, 32'h0000_0044);
    p0 = pulses;
    wr(2'd1, 10);
    wait_cyc(5);
    wr(2'd1, 10);
    wait_cyc(7);
    check("R4 restart delays", pulses - p0, 0);
    wait_cyc(5);
    check("R4 restart fires once", pulses - p0, 1);

    // R10 current count is read-only
    wr(2'd2, 32'h55);
    rd(2'd2, v); check("R10 write ignored", v, 0);

    // R9 software enable and write mask
    @(negedge clk); sw_enable = 1'b0;
    wait_cyc(2);
    rd(2'd0, v); check("R9 mask forced", v, 'h10044);
    wr(2'd0, 32'h0002_0045);
    rd(2'd0, v); check("R9 masked write", v, 'h30045);
    @(negedge clk); sw_enable = 1'b1;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R9 writable bits", v, 'h300FF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule